// File: doc/BRIEF.md
# Parallel-Port Unlock Sequence Detector

This block sits on the device side of a parallel-port peripheral. It samples the host's 8-bit data lines and 4-bit control lines through synchronisers and looks for a fixed seven-byte unlock key followed by a command byte. The command only takes effect when the host then pulses the control lines from the idle value to the strobe value and back. While the key is in progress, the block shows a 12-bit identity one nibble at a time on a 4-bit status output, so the host can confirm that a compatible adapter is present before it commits.

A committed command produces a one-cycle `cmdPulse`. The connect command sets the `linkUp` flag. The disconnect command clears it. A no-operation command is accepted and pulses, but leaves the flag alone. The adapter logic behind the block uses `linkUp` to decide whether the port now belongs to it.

Top module: `pp_unlock_detect`

## Requirements
- R1: After reset, `statusNib` is 0x0, `linkUp` is 0 and `cmdPulse` is 0.
- R2: The key bytes 0xFE, 0xAA, 0x55, 0x00, 0xFF, 0x87, 0x78 in order, then command 0x20, then control 0x5 followed by control 0x4, produce one `cmdPulse` and set `linkUp` to 1.
- R3: The same sequence with command 0x30 produces one `cmdPulse` and clears `linkUp` to 0.
- R4: The same sequence with command 0x00 produces one `cmdPulse` and leaves `linkUp` unchanged.
- R5: `statusNib` reads 0xB once the fifth key byte (0xFF) has been taken, 0x5 once the sixth (0x87) has been taken, and 0x0 once the seventh (0x78) has been taken.
- R6: Only while the control strobe value 0x5 is held after command 0x20 does `statusNib` read 0xF. With command 0x00 or 0x30 it reads 0x0 at that point.
- R7: A data byte that differs from the expected next key byte sends the matcher back to idle. The status nibble returns to 0x0, and the rest of the sequence then commits nothing.
- R8: A mismatching byte equal to 0xFE is counted as the first key byte of a new attempt.
- R9: After a command byte, a control value other than 0x4 or 0x5, or a new data byte, abandons the command without a pulse.
- R10: A command byte other than 0x00, 0x20 or 0x30 abandons the sequence, even if a strobe follows.
- R11: `cmdPulse` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostData | input | 8 | Host data lines (asynchronous) |
| hostCtrl | input | 4 | Host control lines (asynchronous) |
| statusNib | output | 4 | Identity nibble returned on the upper status lines |
| linkUp | output | 1 | High from a connect command until a disconnect command |
| cmdPulse | output | 1 | One-cycle pulse for each committed command |

## Verification
The main pattern is the complete key with each of the three accepted commands. Comparing these runs shows whether the flag is set, cleared or left alone, and whether the 0xF nibble depends on the command. Broken variants probe the matcher's recovery: a wrong byte mid-key checks the return to idle, and a repeated 0xFE with a restart checks that the restart is counted as step one. A strobe interrupted by a stray control value, a data byte landing between command and strobe, and an unknown command code each tell a real commit apart from a near miss.

// File: rtl/pp_unlock_pkg.sv
package pp_unlock_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int KEY_LEN = 7;
  localparam int CNT_W  = $clog2(KEY_LEN + 1);

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_CMD,
    PH_STB_HI,
    PH_STB_LO
  } phase_t;

  typedef enum logic [1:0] {
    NIB_NONE,
    NIB_FIRST,
    NIB_SECOND,
    NIB_THIRD
  } nibSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic    loadCmd;
    logic    commit;
    nibSel_t nibSel;
  } ctrlStrobes_t;

  // Unlock key, indexed by number of bytes already matched
  function automatic logic [BYTE_W-1:0] keyByte(input logic [CNT_W-1:0] idx);
    logic [BYTE_W-1:0] k;
    case (idx)
      3'd0:    k = 8'hFE;
      3'd1:    k = 8'hAA;
      3'd2:    k = 8'h55;
      3'd3:    k = 8'h00;
      3'd4:    k = 8'hFF;
      3'd5:    k = 8'h87;
      3'd6:    k = 8'h78;
      default: k = 8'hFE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/pp_unlock_datapath.sv
module pp_unlock_datapath
  import pp_unlock_pkg::*;
#(
  parameter int CTRL_W = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [3*NIB_W-1:0] IDENT_CODE = 12'hB5F,
  parameter logic [BYTE_W-1:0] CMD_CONNECT = 8'h20,
  parameter logic [BYTE_W-1:0] CMD_DISCONNECT = 8'h30,
  parameter logic [BYTE_W-1:0] CMD_NOP = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] hostData,
  input  logic [CTRL_W-1:0] hostCtrl,
  input  ctrlStrobes_t      strobes,
  output logic              byteEvt,
  output logic [BYTE_W-1:0] byteVal,
  output logic              ctrlEvt,
  output logic [CTRL_W-1:0] ctrlVal,
  output logic              cmdKnown,
  output logic              cmdIsConnect,
  output logic [NIB_W-1:0]  statusNib,
  output logic              linkUp,
  output logic              cmdPulse
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [BYTE_W-1:0] dSync [SYNC_STAGES];
  logic [CTRL_W-1:0] cSync [SYNC_STAGES];
  logic [BYTE_W-1:0] prevData;
  logic [CTRL_W-1:0] prevCtrl;
  logic [BYTE_W-1:0] cmdReg;

  // Synchroniser chains for the asynchronous host lines
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dSync[0] <= '0;
          cSync[0] <= '0;
        end else begin
          dSync[0] <= hostData;
          cSync[0] <= hostCtrl;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dSync[s] <= '0;
          cSync[s] <= '0;
        end else begin
          dSync[s] <= dSync[s-1];
          cSync[s] <= cSync[s-1];
        end
      end
    end
  end

  // Change detection: only a new value is an event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevData <= '0;
      prevCtrl <= '0;
    end else begin
      prevData <= dSync[LAST];
      prevCtrl <= cSync[LAST];
    end
  end

  assign byteVal = dSync[LAST];
  assign ctrlVal = cSync[LAST];
  assign byteEvt = (dSync[LAST] != prevData);
  assign ctrlEvt = (cSync[LAST] != prevCtrl);

  assign cmdKnown = (byteVal == CMD_CONNECT) || (byteVal == CMD_DISCONNECT) ||
                    (byteVal == CMD_NOP);
  assign cmdIsConnect = (cmdReg == CMD_CONNECT);

  // Command holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= CMD_NOP;
    end else if (strobes.loadCmd) begin
      cmdReg <= byteVal;
    end
  end

  // Commit side: pulse and link flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPulse <= 1'b0;
      linkUp   <= 1'b0;
    end else begin
      cmdPulse <= strobes.commit;
      if (strobes.commit) begin
        if (cmdReg == CMD_CONNECT) begin
          linkUp <= 1'b1;
        end else if (cmdReg == CMD_DISCONNECT) begin
          linkUp <= 1'b0;
        end
      end
    end
  end

  // Identity nibble presented on the status lines
  logic [NIB_W-1:0] nibNext;
  always_comb begin
    case (strobes.nibSel)
      NIB_FIRST:  nibNext = IDENT_CODE[3*NIB_W-1:2*NIB_W];
      NIB_SECOND: nibNext = IDENT_CODE[2*NIB_W-1:NIB_W];
      NIB_THIRD:  nibNext = IDENT_CODE[NIB_W-1:0];
      default:    nibNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusNib <= '0;
    end else begin
      statusNib <= nibNext;
    end
  end

endmodule

// File: rtl/pp_unlock_ctrl.sv
module pp_unlock_ctrl
  import pp_unlock_pkg::*;
#(
  parameter int CTRL_W = 4,
  parameter logic [CTRL_W-1:0] CTRL_IDLE = 4'h4,
  parameter logic [CTRL_W-1:0] CTRL_STROBE = 4'h5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteEvt,
  input  logic [BYTE_W-1:0] byteVal,
  input  logic              ctrlEvt,
  input  logic [CTRL_W-1:0] ctrlVal,
  input  logic              cmdKnown,
  input  logic              cmdIsConnect,
  output ctrlStrobes_t      strobes
);

  localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0] FIRST_NIB = CNT_W'(KEY_LEN - 2);
  localparam logic [CNT_W-1:0] SECOND_NIB = CNT_W'(KEY_LEN - 1);
  localparam logic [CNT_W-1:0] ZERO_IDX  = '0;

  phase_t phase, phaseNext;
  logic [CNT_W-1:0] matchCnt, cntNext;
  logic [CNT_W-1:0] restartCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_HUNT;
      matchCnt <= '0;
    end else begin
      phase    <= phaseNext;
      matchCnt <= cntNext;
    end
  end

  // A rejected byte equal to the first key byte starts a new attempt
  assign restartCnt = (byteVal == keyByte(ZERO_IDX)) ? CNT_W'(1) : '0;

  always_comb begin
    phaseNext       = phase;
    cntNext         = matchCnt;
    strobes.loadCmd = 1'b0;
    strobes.commit  = 1'b0;
    strobes.nibSel  = NIB_NONE;

    case (phase)
      PH_HUNT: begin
        if (byteEvt) begin
          if (byteVal == keyByte(matchCnt)) begin
            if (matchCnt == LAST_IDX) begin
              phaseNext = PH_CMD;
              cntNext   = '0;
            end else begin
              cntNext = matchCnt + 1'b1;
            end
          end else begin
            cntNext = restartCnt;
          end
        end
      end

      PH_CMD: begin
        if (byteEvt) begin
          if (cmdKnown) begin
            strobes.loadCmd = 1'b1;
            phaseNext       = PH_STB_HI;
          end else begin
            phaseNext = PH_HUNT;
            cntNext   = restartCnt;
          end
        end
      end

      PH_STB_HI: begin
        if (byteEvt) begin
          phaseNext = PH_HUNT;
          cntNext   = restartCnt;
        end else if (ctrlEvt) begin
          if (ctrlVal == CTRL_STROBE) begin
            phaseNext = PH_STB_LO;
          end else if (ctrlVal != CTRL_IDLE) begin
            phaseNext = PH_HUNT;
            cntNext   = '0;
          end
        end
      end

      PH_STB_LO: begin
        if (byteEvt) begin
          phaseNext = PH_HUNT;
          cntNext   = restartCnt;
        end else if (ctrlEvt) begin
          phaseNext = PH_HUNT;
          cntNext   = '0;
          if (ctrlVal == CTRL_IDLE) begin
            strobes.commit = 1'b1;
          end
        end
      end

      default: begin
        phaseNext = PH_HUNT;
        cntNext   = '0;
      end
    endcase

    // Nibble selection follows the current position in the pattern
    if (phase == PH_HUNT && matchCnt == FIRST_NIB) begin
      strobes.nibSel = NIB_FIRST;
    end else if (phase == PH_HUNT && matchCnt == SECOND_NIB) begin
      strobes.nibSel = NIB_SECOND;
    end else if (phase == PH_STB_LO && cmdIsConnect) begin
      strobes.nibSel = NIB_THIRD;
    end
  end

endmodule

// File: rtl/pp_unlock_detect.sv
module pp_unlock_detect
  import pp_unlock_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [11:0] IDENT_CODE = 12'hB5F,
  parameter logic [7:0] CMD_CONNECT = 8'h20,
  parameter logic [7:0] CMD_DISCONNECT = 8'h30,
  parameter logic [7:0] CMD_NOP = 8'h00,
  parameter logic [3:0] CTRL_IDLE = 4'h4,
  parameter logic [3:0] CTRL_STROBE = 4'h5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] hostData,
  input  logic [3:0] hostCtrl,
  output logic [3:0] statusNib,
  output logic       linkUp,
  output logic       cmdPulse
);

  localparam int CTRL_W = 4;

  ctrlStrobes_t      strobes;
  logic              byteEvt;
  logic [BYTE_W-1:0] byteVal;
  logic              ctrlEvt;
  logic [CTRL_W-1:0] ctrlVal;
  logic              cmdKnown;
  logic              cmdIsConnect;

  pp_unlock_ctrl #(
    .CTRL_W      (CTRL_W),
    .CTRL_IDLE   (CTRL_IDLE),
    .CTRL_STROBE (CTRL_STROBE)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .byteEvt      (byteEvt),
    .byteVal      (byteVal),
    .ctrlEvt      (ctrlEvt),
    .ctrlVal      (ctrlVal),
    .cmdKnown     (cmdKnown),
    .cmdIsConnect (cmdIsConnect),
    .strobes      (strobes)
  );

  pp_unlock_datapath #(
    .CTRL_W         (CTRL_W),
    .SYNC_STAGES    (SYNC_STAGES),
    .IDENT_CODE     (IDENT_CODE),
    .CMD_CONNECT    (CMD_CONNECT),
    .CMD_DISCONNECT (CMD_DISCONNECT),
    .CMD_NOP        (CMD_NOP)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .hostData     (hostData),
    .hostCtrl     (hostCtrl),
    .strobes      (strobes),
    .byteEvt      (byteEvt),
    .byteVal      (byteVal),
    .ctrlEvt      (ctrlEvt),
    .ctrlVal      (ctrlVal),
    .cmdKnown     (cmdKnown),
    .cmdIsConnect (cmdIsConnect),
    .statusNib    (statusNib),
    .linkUp       (linkUp),
    .cmdPulse     (cmdPulse)
  );

endmodule

// File: rtl/pp_unlock_detect_checker.sv
module pp_unlock_detect_checker (
  input logic       clk,
  input logic       rstN,
  input logic [3:0] statusNib,
  input logic       linkUp,
  input logic       cmdPulse
);

  assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    cmdPulse |=> !cmdPulse);

  assert_link_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |-> cmdPulse);

  assert_link_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkUp) |-> cmdPulse);

  assert_nib_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusNib == 4'h0) || (statusNib == 4'hB) ||
    (statusNib == 4'h5) || (statusNib == 4'hF));

  assert_nib_steps_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusNib == 4'h5) |-> ($past(statusNib) == 4'hB) || ($past(statusNib) == 4'h5));

endmodule

bind pp_unlock_detect pp_unlock_detect_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .statusNib (statusNib),
  .linkUp    (linkUp),
  .cmdPulse  (cmdPulse)
);

// File: tb/pp_unlock_detect_test.sv
module pp_unlock_detect_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] hostData = 8'hFF;
  logic [3:0] hostCtrl = 4'h4;
  logic [3:0] statusNib;
  logic       linkUp;
  logic       cmdPulse;

  int checkCnt = 0;
  int failCnt = 0;
  int pulseCnt = 0;
  int runLen = 0;
  int maxRun = 0;
  int expPulses = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pp_unlock_detect uut (
    .clk       (clk),
    .rstN      (rstN),
    .hostData  (hostData),
    .hostCtrl  (hostCtrl),
    .statusNib (statusNib),
    .linkUp    (linkUp),
    .cmdPulse  (cmdPulse)
  );

  // Pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN && cmdPulse) begin
      pulseCnt++;
      runLen++;
      if (runLen > maxRun) maxRun = runLen;
    end else begin
      runLen = 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic putByte(input logic [7:0] b);
    @(negedge clk);
    hostData = b;
    repeat (6) @(negedge clk);
  endtask

  task automatic putCtrl(input logic [3:0] c);
    @(negedge clk);
    hostCtrl = c;
    repeat (6) @(negedge clk);
  endtask

  task automatic sendKey();
    putByte(8'hFE); putByte(8'hAA); putByte(8'h55); putByte(8'h00);
    putByte(8'hFF); putByte(8'h87); putByte(8'h78);
  endtask

  task automatic testReset();
    check("R1 nibble", statusNib, 0);
    check("R1 linkUp", linkUp, 0);
    check("R1 cmdPulse", pulseCnt, 0);
  endtask

  task automatic testConnect();
    putByte(8'hFE); putByte(8'hAA); putByte(8'h55); putByte(8'h00);
    putByte(8'hFF);
    check("R5 nibble after fifth byte", statusNib, 4'hB);
    putByte(8'h87);
    check("R5 nibble after sixth byte", statusNib, 4'h5);
    putByte(8'h78);
    check("R5 nibble after seventh byte", statusNib, 4'h0);
    putByte(8'h20);
    check("R6 nibble before strobe", statusNib, 4'h0);
    putCtrl(4'h5);
    check("R6 nibble during strobe connect", statusNib, 4'hF);
    putCtrl(4'h4);
    expPulses++;
    check("R2 pulse count", pulseCnt, expPulses);
    check("R2 linkUp set", linkUp, 1);
    check("R6 nibble after commit", statusNib, 4'h0);
    putByte(8'hFF);
  endtask

  task automatic testNop();
    sendKey();
    putByte(8'h00);
    putCtrl(4'h5);
    check("R6 nibble during strobe nop", statusNib, 4'h0);
    putCtrl(4'h4);
    expPulses++;
    check("R4 pulse count", pulseCnt, expPulses);
    check("R4 linkUp kept", linkUp, 1);
    putByte(8'hFF);
  endtask

  task automatic testDisconnect(input int expAfter);
    sendKey();
    putByte(8'h30);
    putCtrl(4'h5);
    check("R6 nibble during strobe disconnect", statusNib, 4'h0);
    putCtrl(4'h4);
    expPulses++;
    check("R3 pulse count", pulseCnt, expPulses);
    check("R3 linkUp cleared", linkUp, expAfter);
    putByte(8'hFF);
  endtask

  task automatic testBadByte();
    putByte(8'hFE); putByte(8'hAA); putByte(8'h33); putByte(8'h55);
    putByte(8'h00); putByte(8'hFF);
    check("R7 nibble after broken key", statusNib, 4'h0);
    putByte(8'h87); putByte(8'h78); putByte(8'h20);
    putCtrl(4'h5); putCtrl(4'h4);
    check("R7 no pulse", pulseCnt, expPulses);
    check("R7 linkUp unchanged", linkUp, 0);
    putByte(8'hFF);
  endtask

  task automatic testRestart();
    putByte(8'hFE); putByte(8'hAA); putByte(8'hFE); putByte(8'hAA);
    putByte(8'h55); putByte(8'h00); putByte(8'hFF);
    check("R8 nibble after restart", statusNib, 4'hB);
    putByte(8'h87); putByte(8'h78); putByte(8'h20);
    putCtrl(4'h5); putCtrl(4'h4);
    expPulses++;
    check("R8 pulse count", pulseCnt, expPulses);
    check("R8 linkUp set", linkUp, 1);
    putByte(8'hFF);
  endtask

  task automatic testNoStrobe();
    sendKey();
    putByte(8'h30);
    putCtrl(4'h6); putCtrl(4'h4); putCtrl(4'h5); putCtrl(4'h4);
    check("R9 no pulse after stray control", pulseCnt, expPulses);
    check("R9 linkUp kept after stray control", linkUp, 1);
    sendKey();
    putByte(8'h30);
    putByte(8'hFF);
    putCtrl(4'h5); putCtrl(4'h4);
    check("R9 no pulse after data interrupt", pulseCnt, expPulses);
    check("R9 linkUp kept after data interrupt", linkUp, 1);
  endtask

  task automatic testBadCmd();
    sendKey();
    putByte(8'h40);
    putCtrl(4'h5); putCtrl(4'h4);
    check("R10 no pulse on unknown command", pulseCnt, expPulses);
    check("R10 linkUp kept", linkUp, 1);
    putByte(8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (6) @(negedge clk);
    testReset();
    testConnect();
    testNop();
    testDisconnect(0);
    testBadByte();
    testRestart();
    testNoStrobe();
    testBadCmd();
    testDisconnect(0);
    check("R11 pulse width", maxRun, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

endmodule